// File: doc/BRIEF.md
# TDM Frame Sync Receiver with Superframe Detection

This block watches the frame sync line of a serial TDM line interface. The line is sampled on every rising edge of the data clock, and a frame repeats at 8 kHz. A rising sync marks the first B-channel bit of a frame. The sync is normally two clocks wide. Some line transceivers shorten it to a single clock once every 12 ms, which is every 96 frames, to mark a superframe boundary. The block accepts both widths as a valid frame start.

Each pulse is classified by the number of clocks it stays high:

- One clock is a superframe marker.
- Two clocks is an ordinary frame.
- Three or more clocks is a width error.

The block also provides:

- a one-clock frame-start strobe;
- a bit position counter within the frame;
- a count of frames since the last superframe marker;
- a flag for a marker that arrives at the wrong spacing;
- a sync-lost flag, raised when no new frame starts within the expected frame length plus a tolerance.

The pulse width is tracked by a four-state machine:

| State | Meaning | Transitions |
|-------|---------|-------------|
| `ST_LOW` | Waiting for sync | Goes to `ST_HI1` on a high sample. This is the frame start. |
| `ST_HI1` | High for one clock | Goes to `ST_HI2` if sync stays high. Returns to `ST_LOW` on a low sample and classifies the pulse as a marker. |
| `ST_HI2` | High for two clocks | Goes to `ST_HIX` if sync stays high. Returns to `ST_LOW` on a low sample and classifies the pulse as a normal frame. |
| `ST_HIX` | High for three or more clocks | Stays in `ST_HIX` while sync is high. Returns to `ST_LOW` on a low sample and reports a width error. |

Top module: `tdm_fsync_rx`

## Requirements
- R1: While reset is asserted, and on its release, all outputs are 0: `frame_start`, `sf_mark`, `norm_mark`, `width_err`, `sync_lost`, `bit_cnt`, `sf_cnt` and `sf_mismatch`.
- R2: `frame_start` is high for exactly one clock, in the cycle after the first high sample of `fsync_in`. This holds for any pulse width.
- R3: `bit_cnt` reads 0 in the `frame_start` cycle. It then rises by 1 on each clock until the next frame start, and saturates at all ones.
- R4: A pulse that is high for exactly one sample raises `sf_mark` for one clock, one cycle after `frame_start`.
- R5: A pulse that is high for exactly two samples raises `norm_mark` for one clock, two cycles after `frame_start`.
- R6: A pulse that is high for three or more samples raises `width_err` for one clock, in the cycle after its first low sample. It still produces `frame_start`.
- R7: `sync_lost` becomes 1 in the cycle after `bit_cnt` reads `frame_len` + `TOL` (default `TOL` is 4), provided no new frame has started.
- R8: `sync_lost` returns to 0 in the cycle in which `sf_mark` or `norm_mark` is high. A width error leaves it unchanged.
- R9: `sf_cnt` rises by 1 in each `frame_start` cycle, saturating at all ones. It reads 0 in the cycle in which `sf_mark` is high.
- R10: `sf_mismatch` is high, together with `sf_mark`, only when both of the following hold:
  - a marker has already been seen since reset;
  - `sf_cnt`, as read in the `frame_start` cycle of the marker frame, differs from `SF_FRAMES` (default 96).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock; sync is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_in | input | 1 | Incoming frame sync |
| frame_len | input | CNT_W (10) | Expected frame length in clocks |
| frame_start | output | 1 | One-clock strobe at the first B-channel bit |
| sf_mark | output | 1 | Superframe marker pulse (one-clock-wide sync seen) |
| norm_mark | output | 1 | Normal frame pulse (two-clock-wide sync seen) |
| width_err | output | 1 | Sync pulse of illegal width |
| sync_lost | output | 1 | No frame start within `frame_len` + `TOL` clocks |
| bit_cnt | output | CNT_W (10) | Bit position within the current frame |
| sf_cnt | output | SF_W (8) | Frames since the last superframe marker |
| sf_mismatch | output | 1 | Marker arrived at a spacing other than `SF_FRAMES` |

## Verification
Every output is registered once behind the sampled sync. A sync driven high in bench step 0 therefore yields `frame_start`, `bit_cnt` = 0 and the incremented `sf_cnt` at the next sample point (step 1). The classification pulse for a pulse of width w, together with any `sync_lost` clear and `sf_mismatch`, appears at step w+1. `sync_lost` rises at step `frame_len` + `TOL` + 2.

The bench drives `fsync_in` on falling clock edges and reads all outputs just before it drives. At each step it compares the outputs against step-indexed expectations derived from these latencies, so no result depends on process order at the active edge.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;

    typedef enum logic [1:0] {
        ST_LOW = 2'd0,
        ST_HI1 = 2'd1,
        ST_HI2 = 2'd2,
        ST_HIX = 2'd3
    } sync_state_e;

    typedef struct packed {
        logic start;
        logic marker;
        logic normal;
        logic bad;
    } sync_evt_t;

endpackage

// File: rtl/sync_width_fsm.sv
module sync_width_fsm
    import tdm_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_in,
    output logic      start_now,
    output logic      marker_now,
    output logic      valid_now,
    output sync_evt_t evt_q
);

    sync_state_e state_q;
    sync_state_e state_d;
    sync_evt_t   evt_d;

    // Next state and per-edge classification
    always_comb begin
        state_d = state_q;
        evt_d   = '0;
        unique case (state_q)
            ST_LOW: begin
                if (sync_in) begin
                    state_d     = ST_HI1;
                    evt_d.start = 1'b1;
                end
            end
            ST_HI1: begin
                if (sync_in) begin
                    state_d = ST_HI2;
                end else begin
                    state_d      = ST_LOW;
                    evt_d.marker = 1'b1;
                end
            end
            ST_HI2: begin
                if (sync_in) begin
                    state_d = ST_HIX;
                end else begin
                    state_d      = ST_LOW;
                    evt_d.normal = 1'b1;
                end
            end
            ST_HIX: begin
                if (!sync_in) begin
                    state_d   = ST_LOW;
                    evt_d.bad = 1'b1;
                end
            end
            default: state_d = ST_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered output strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign start_now  = evt_d.start;
    assign marker_now = evt_d.marker;
    assign valid_now  = evt_d.marker | evt_d.normal;

    assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_q));

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.start |=> !evt_q.start);

    assert_marker_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.marker |-> $past(evt_q.start));

    assert_normal_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.normal |-> $past(evt_q.start, 2));

endmodule

// File: rtl/frame_bit_counter.sv
module frame_bit_counter #(
    parameter int CNT_W = 10,
    parameter int TOL   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_evt,
    input  logic             valid_evt,
    input  logic [CNT_W-1:0] frame_len,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             sync_lost
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W:0]   TOL_X   = (CNT_W + 1)'(TOL);

    logic [CNT_W:0] limit;
    logic           overdue;

    assign limit   = {1'b0, frame_len} + TOL_X;
    assign overdue = ({1'b0, bit_cnt} >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            sync_lost <= 1'b0;
        end else begin
            if (start_evt) begin
                bit_cnt <= '0;
            end else if (bit_cnt != CNT_MAX) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (valid_evt) begin
                sync_lost <= 1'b0;
            end else if (!start_evt && overdue) begin
                sync_lost <= 1'b1;
            end
        end
    end

    assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> bit_cnt == '0);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_evt && bit_cnt != CNT_MAX) |=> bit_cnt == $past(bit_cnt) + 1'b1);

    assert_lost_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_lost) |-> ($past({1'b0, bit_cnt}) >= $past(limit)));

    assert_lost_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_evt |=> !sync_lost);

endmodule

// File: rtl/superframe_tracker.sv
module superframe_tracker #(
    parameter int SF_W      = 8,
    parameter int SF_FRAMES = 96
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_evt,
    input  logic            marker_evt,
    output logic [SF_W-1:0] sf_cnt,
    output logic            sf_mismatch
);

    localparam logic [SF_W-1:0] SF_MAX  = '1;
    localparam logic [SF_W-1:0] SF_GOAL = SF_W'(SF_FRAMES);

    logic sf_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sf_cnt      <= '0;
            sf_seen     <= 1'b0;
            sf_mismatch <= 1'b0;
        end else begin
            sf_mismatch <= marker_evt && sf_seen && (sf_cnt != SF_GOAL);
            if (marker_evt) begin
                sf_cnt  <= '0;
                sf_seen <= 1'b1;
            end else if (start_evt && sf_cnt != SF_MAX) begin
                sf_cnt <= sf_cnt + 1'b1;
            end
        end
    end

    assert_marker_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        marker_evt |=> sf_cnt == '0);

    assert_sf_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && sf_cnt != SF_MAX) |=> sf_cnt == $past(sf_cnt) + 1'b1);

    assert_no_mismatch_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(marker_evt) |-> !sf_mismatch);

endmodule

// File: rtl/tdm_fsync_rx.sv
module tdm_fsync_rx
    import tdm_sync_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int TOL       = 4,
    parameter int SF_W      = 8,
    parameter int SF_FRAMES = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_in,
    input  logic [CNT_W-1:0] frame_len,
    output logic             frame_start,
    output logic             sf_mark,
    output logic             norm_mark,
    output logic             width_err,
    output logic             sync_lost,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [SF_W-1:0]  sf_cnt,
    output logic             sf_mismatch
);

    logic      start_now;
    logic      marker_now;
    logic      valid_now;
    sync_evt_t evt_q;

    sync_width_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (fsync_in),
        .start_now  (start_now),
        .marker_now (marker_now),
        .valid_now  (valid_now),
        .evt_q      (evt_q)
    );

    frame_bit_counter #(
        .CNT_W (CNT_W),
        .TOL   (TOL)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_now),
        .valid_evt (valid_now),
        .frame_len (frame_len),
        .bit_cnt   (bit_cnt),
        .sync_lost (sync_lost)
    );

    superframe_tracker #(
        .SF_W      (SF_W),
        .SF_FRAMES (SF_FRAMES)
    ) u_sf (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_evt   (start_now),
        .marker_evt  (marker_now),
        .sf_cnt      (sf_cnt),
        .sf_mismatch (sf_mismatch)
    );

    assign frame_start = evt_q.start;
    assign sf_mark     = evt_q.marker;
    assign norm_mark   = evt_q.normal;
    assign width_err   = evt_q.bad;

    assert_mismatch_marker_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sf_mismatch |-> sf_mark);

    assert_start_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> bit_cnt == '0);

    assert_mark_zero_sf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sf_mark |-> sf_cnt == '0);

endmodule

// File: tb/tdm_fsync_rx_tb_top.sv
`timescale 1ns/1ps
module tdm_fsync_rx_tb_top;

    localparam int CNT_W = 10;
    localparam int SF_W  = 8;
    localparam int FLEN  = 32;
    localparam int TOLV  = 4;
    localparam int LIM   = FLEN + TOLV;
    localparam int SFN   = 96;
    localparam int NV    = 12;

    // Each entry: pulse width, frame period in clocks
    localparam int VW [NV] = '{2, 2, 1, 2, 3, 2, 1, 5, 2, 3, 2, 2};
    localparam int VP [NV] = '{32, 32, 32, 32, 32, 32, 32, 32, 45, 32, 32, 32};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fsync_in = 1'b0;
    logic [CNT_W-1:0] frame_len = CNT_W'(FLEN);
    logic             frame_start, sf_mark, norm_mark, width_err, sync_lost, sf_mismatch;
    logic [CNT_W-1:0] bit_cnt;
    logic [SF_W-1:0]  sf_cnt;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    // bench model of the requirements
    int  sf_m = 0;
    bit  sf_seen_m = 1'b0;
    bit  lost_m = 1'b0;
    bit  first = 1'b1;
    int  prev_p = 0;

    always #5 clk = ~clk;

    tdm_fsync_rx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync_in    (fsync_in),
        .frame_len   (frame_len),
        .frame_start (frame_start),
        .sf_mark     (sf_mark),
        .norm_mark   (norm_mark),
        .width_err   (width_err),
        .sync_lost   (sync_lost),
        .bit_cnt     (bit_cnt),
        .sf_cnt      (sf_cnt),
        .sf_mismatch (sf_mismatch)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic reset_model();
        sf_m      = 0;
        sf_seen_m = 1'b0;
        lost_m    = 1'b0;
        first     = 1'b1;
    endtask

    task automatic check_all_zero();
        chk("R1 frame_start", int'(frame_start), 0);
        chk("R1 sf_mark", int'(sf_mark), 0);
        chk("R1 norm_mark", int'(norm_mark), 0);
        chk("R1 width_err", int'(width_err), 0);
        chk("R1 sync_lost", int'(sync_lost), 0);
        chk("R1 bit_cnt", int'(bit_cnt), 0);
        chk("R1 sf_cnt", int'(sf_cnt), 0);
        chk("R1 sf_mismatch", int'(sf_mismatch), 0);
    endtask

    // One frame: sync high for w steps, period p steps; outputs read before each drive
    task automatic run_frame(input int w, input int p);
        bit exp_mis;
        bit at_cls;
        for (int j = 0; j < p; j++) begin
            @(negedge clk);
            if (j == 0) begin
                if (!first) begin
                    if (prev_p >= LIM + 2) lost_m = 1'b1;
                    chk("R2 frame_start idle", int'(frame_start), 0);
                    chk("R3 bit_cnt end", int'(bit_cnt), prev_p - 1);
                    chk("R7 sync_lost", int'(sync_lost), int'(lost_m));
                end
                first = 1'b0;
            end else begin
                at_cls  = (j == w + 1);
                exp_mis = 1'b0;
                if (j == 1) sf_m = (sf_m == 255) ? 255 : sf_m + 1;
                if (at_cls && w == 1) begin
                    exp_mis   = sf_seen_m && (sf_m != SFN);
                    sf_m      = 0;
                    sf_seen_m = 1'b1;
                end
                if (at_cls && (w == 1 || w == 2)) lost_m = 1'b0;
                else if (j >= LIM + 2) lost_m = 1'b1;
                chk("R2 frame_start", int'(frame_start), int'(j == 1));
                chk("R3 bit_cnt", int'(bit_cnt), j - 1);
                chk("R4 sf_mark", int'(sf_mark), int'(at_cls && w == 1));
                chk("R5 norm_mark", int'(norm_mark), int'(at_cls && w == 2));
                chk("R6 width_err", int'(width_err), int'(at_cls && w >= 3));
                if (at_cls) chk("R8 sync_lost", int'(sync_lost), int'(lost_m));
                else        chk("R7 sync_lost", int'(sync_lost), int'(lost_m));
                chk("R9 sf_cnt", int'(sf_cnt), sf_m);
                chk("R10 sf_mismatch", int'(sf_mismatch), int'(exp_mis));
            end
            fsync_in = (j < w);
        end
        prev_p = p;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all_zero();                 // R1 reset state
        rst_n = 1'b1;
        reset_model();

        // table walk: widths 1, 2, 3+, lost and recovery
        for (int v = 0; v < NV; v++) begin
            run_frame(VW[v], VP[v]);
        end

        // R1: reset in the middle of a pulse
        @(negedge clk);
        fsync_in = 1'b1;
        rst_n    = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_all_zero();
        fsync_in = 1'b0;
        rst_n    = 1'b1;
        reset_model();

        // R10: correct superframe spacing, then a marker one frame later
        run_frame(1, FLEN);
        for (int f = 0; f < SFN - 1; f++) begin
            run_frame(2, FLEN);
        end
        run_frame(1, FLEN);               // spacing 96: no mismatch
        run_frame(1, FLEN);               // spacing 1: mismatch
        run_frame(2, FLEN);

        // R7: sync stops entirely after one frame
        run_frame(2, LIM + 6);
        @(negedge clk);
        chk("R7 sync_lost held", int'(sync_lost), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule